// File: doc/BRIEF.md
# MDIO Command Engine

This block is a management-bus master that sits behind a single 32-bit command/status word. Software writes the word with the request flag set. The engine then captures the fields and runs one clause-22 management frame on the MDC/MDIO pins. It drops the request flag when the frame has finished. On a read, the 16 bits returned by the PHY land in the low half of the same word, so software can poll one location both to learn that the transfer is complete and to collect the result.

The serial clock comes from a divider on the system clock. The divider runs only while a frame is in flight; otherwise MDC rests low. The master changes MDIO on the falling edge of MDC. On a read, the PHY's bits are captured on the rising edge.

The controller has nine states:
- `ST_IDLE` waits for a request.
- `ST_PRE` sends 32 ones.
- `ST_SOF` sends the start code.
- `ST_OPC` sends the opcode.
- `ST_PHY` sends the PHY address.
- `ST_REG` sends the register address.
- `ST_TA` is the turnaround.
- `ST_DAT` carries the 16 data bits.
- `ST_DONE` hands the result back.

The transitions are:
- `ST_IDLE` to `ST_PRE` on a captured request.
- Each frame state to the next, in the order listed, on the MDC falling edge that ends that state's last bit.
- `ST_DAT` to `ST_DONE` in the same way.
- `ST_DONE` to `ST_IDLE` unconditionally one cycle later.

Top module: `mdio_cmd_engine`

## Requirements
- R1: Reset clears the register readback to 0, holds MDC low and leaves MDIO undriven (`mdio_oe` = 0).
- R2: A write with bit 31 set while idle starts a frame. Bit 31 reads back 1 from the cycle after that write until the frame is complete, then reads 0.
- R3: Command word layout is as follows:
  - bit 30 = 1 selects a read and 0 selects a write;
  - bits 25:21 carry the PHY address;
  - bits 20:16 carry the register address;
  - bits 15:0 carry the write data;
  - bits 29:26 always read back 0.
- R4: Each MDC high and low phase lasts `DIV_HALF` system clocks (2 by default). MDC stays low while no frame is active.
- R5: A frame is 64 bits, sent MSB first, in this order:
  - 32 ones;
  - start code 01;
  - opcode 01 for a write or 10 for a read;
  - 5 PHY address bits;
  - 5 register address bits;
  - 2 turnaround bits;
  - 16 data bits.
- R6: While the master drives MDIO, its value changes only in the cycle in which MDC falls. Read data is taken at MDC rising edges.
- R7: In a write turnaround the master drives 1 then 0. In a read it releases MDIO (`mdio_oe` = 0) for the turnaround and all 16 data bits.
- R8: After a read completes, bits 15:0 hold the 16 bits the PHY presented, first bit as MSB. After a write completes, bits 15:0 still hold the written data.
- R9: A register write while a frame is in flight changes no readback field, does not alter the frame on the pins and starts no later frame.
- R10: A write with bit 31 clear while idle stores the fields, shows them in the readback, and leaves MDC low and MDIO undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the command word |
| reg_wdata | input | 32 | Command word written by software |
| reg_rdata | output | 32 | Command/status/data readback |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data driven by the master |
| mdio_oe | output | 1 | Output enable for `mdio_o` |
| mdio_i | input | 1 | Management data seen on the pin |

## Verification
The hardest situation to reach from the ports is a second command arriving in the middle of a frame. It must be dropped without disturbing the serial sequence or queuing a follow-on transfer. The bench waits a fixed number of cycles into a write frame, then issues a conflicting read command. It compares the complete 64-bit frame captured at MDC rising edges with the original command and confirms that no further MDC edge appears afterwards. Read returns depend on a PHY model that changes `mdio_i` only after MDC falls. This confirms that capture happens on the rising edge and that bit order is preserved.

// File: rtl/mdio_eng_pkg.sv
`timescale 1ns/1ps
package mdio_eng_pkg;

    // Command word bit positions; software decodes these
    localparam int REQ_BIT   = 31;
    localparam int RD_BIT    = 30;
    localparam int PHY_LSB   = 21;
    localparam int REG_LSB   = 16;
    localparam int ADDR_W    = 5;
    localparam int DATA_W    = 16;
    localparam int PRE_BITS  = 32;
    localparam int HDR_BITS  = 2 + 2 + 2 * ADDR_W + 2;
    localparam int TX_BITS   = HDR_BITS + DATA_W;
    localparam int CNT_W     = 6;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE,
        ST_SOF,
        ST_OPC,
        ST_PHY,
        ST_REG,
        ST_TA,
        ST_DAT,
        ST_DONE
    } mdio_state_e;

    // Number of serial bits spent in each frame state
    function automatic logic [CNT_W-1:0] phase_len(mdio_state_e s);
        logic [CNT_W-1:0] n;
        case (s)
            ST_PRE:  n = CNT_W'(PRE_BITS);
            ST_SOF:  n = CNT_W'(2);
            ST_OPC:  n = CNT_W'(2);
            ST_PHY:  n = CNT_W'(ADDR_W);
            ST_REG:  n = CNT_W'(ADDR_W);
            ST_TA:   n = CNT_W'(2);
            ST_DAT:  n = CNT_W'(DATA_W);
            default: n = CNT_W'(1);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/mdio_clk_div.sv
`timescale 1ns/1ps
module mdio_clk_div #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

    logic [CW-1:0] cnt_q;
    logic          wrap;

    assign wrap      = en && (cnt_q == LAST);
    assign rise_tick = wrap && !mdc;
    assign fall_tick = wrap && mdc;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (!en) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/mdio_cmd_regs.sv
`timescale 1ns/1ps
module mdio_cmd_regs
    import mdio_eng_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              w_req,
    input  logic              w_rd,
    input  logic [ADDR_W-1:0] w_phy,
    input  logic [ADDR_W-1:0] w_reg,
    input  logic [DATA_W-1:0] w_data,
    input  logic              done,
    input  logic [DATA_W-1:0] rx_data,
    output logic              busy,
    output logic              start,
    output logic              f_rd,
    output logic [ADDR_W-1:0] f_phy,
    output logic [ADDR_W-1:0] f_reg,
    output logic [DATA_W-1:0] f_data,
    output logic [31:0]       rdata
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            start  <= 1'b0;
            f_rd   <= 1'b0;
            f_phy  <= '0;
            f_reg  <= '0;
            f_data <= '0;
        end else begin
            start <= 1'b0;
            if (done) begin
                busy <= 1'b0;
                if (f_rd) f_data <= rx_data;
            end else if (wr && !busy) begin
                f_rd   <= w_rd;
                f_phy  <= w_phy;
                f_reg  <= w_reg;
                f_data <= w_data;
                if (w_req) begin
                    busy  <= 1'b1;
                    start <= 1'b1;
                end
            end
        end
    end

    assign rdata = {busy, f_rd, 4'b0000, f_phy, f_reg, f_data};
endmodule

// File: rtl/mdio_frame_fsm.sv
`timescale 1ns/1ps
module mdio_frame_fsm
    import mdio_eng_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rd,
    input  logic [ADDR_W-1:0] phy,
    input  logic [ADDR_W-1:0] regad,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              mdio_i,
    output logic              clk_en,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              done,
    output logic [DATA_W-1:0] rx_data
);
    mdio_state_e        state_q, state_d;
    logic [CNT_W-1:0]   bit_cnt_q;
    logic [TX_BITS-1:0] tx_sr_q;
    logic [DATA_W-1:0]  rx_sr_q;
    logic               rd_q;
    logic               last_bit;
    logic               in_frame;

    assign last_bit = (bit_cnt_q == (phase_len(state_q) - CNT_W'(1)));

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_PRE;
            ST_PRE:  if (fall_tick && last_bit) state_d = ST_SOF;
            ST_SOF:  if (fall_tick && last_bit) state_d = ST_OPC;
            ST_OPC:  if (fall_tick && last_bit) state_d = ST_PHY;
            ST_PHY:  if (fall_tick && last_bit) state_d = ST_REG;
            ST_REG:  if (fall_tick && last_bit) state_d = ST_TA;
            ST_TA:   if (fall_tick && last_bit) state_d = ST_DAT;
            ST_DAT:  if (fall_tick && last_bit) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Bit counter and shift registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            tx_sr_q   <= '0;
            rx_sr_q   <= '0;
            rd_q      <= 1'b0;
        end else if (state_q == ST_IDLE) begin
            bit_cnt_q <= '0;
            if (start) begin
                rd_q    <= rd;
                tx_sr_q <= {2'b01,
                            rd ? 2'b10 : 2'b01,
                            phy, regad,
                            rd ? 2'b11 : 2'b10,
                            rd ? {DATA_W{1'b1}} : wdata};
            end
        end else if (in_frame) begin
            if (fall_tick) begin
                bit_cnt_q <= last_bit ? '0 : bit_cnt_q + CNT_W'(1);
                if (state_q != ST_PRE) tx_sr_q <= tx_sr_q << 1;
            end
            if (rise_tick && rd_q && (state_q == ST_DAT))
                rx_sr_q <= {rx_sr_q[DATA_W-2:0], mdio_i};
        end
    end

    // Outputs
    always_comb begin
        in_frame = 1'b0;
        mdio_oe  = 1'b0;
        mdio_o   = 1'b1;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_PRE: begin
                in_frame = 1'b1;
                mdio_oe  = 1'b1;
            end
            ST_SOF, ST_OPC, ST_PHY, ST_REG: begin
                in_frame = 1'b1;
                mdio_oe  = 1'b1;
                mdio_o   = tx_sr_q[TX_BITS-1];
            end
            ST_TA, ST_DAT: begin
                in_frame = 1'b1;
                mdio_oe  = !rd_q;
                mdio_o   = tx_sr_q[TX_BITS-1];
            end
            ST_DONE: done = 1'b1;
        endcase
    end

    assign clk_en  = in_frame;
    assign rx_data = rx_sr_q;
endmodule

// File: rtl/mdio_cmd_engine.sv
`timescale 1ns/1ps
module mdio_cmd_engine
    import mdio_eng_pkg::*;
#(
    parameter int DIV_HALF = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic              busy, start, done, clk_en, rise_tick, fall_tick;
    logic              f_rd;
    logic [ADDR_W-1:0] f_phy, f_reg;
    logic [DATA_W-1:0] f_data, rx_data;
    logic              unused_wbits;

    assign unused_wbits = ^reg_wdata[29:26];

    mdio_cmd_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .w_req   (reg_wdata[REQ_BIT]),
        .w_rd    (reg_wdata[RD_BIT]),
        .w_phy   (reg_wdata[PHY_LSB +: ADDR_W]),
        .w_reg   (reg_wdata[REG_LSB +: ADDR_W]),
        .w_data  (reg_wdata[DATA_W-1:0]),
        .done    (done),
        .rx_data (rx_data),
        .busy    (busy),
        .start   (start),
        .f_rd    (f_rd),
        .f_phy   (f_phy),
        .f_reg   (f_reg),
        .f_data  (f_data),
        .rdata   (reg_rdata)
    );

    mdio_clk_div #(.DIV_HALF(DIV_HALF)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (clk_en),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .rd        (f_rd),
        .phy       (f_phy),
        .regad     (f_reg),
        .wdata     (f_data),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_i    (mdio_i),
        .clk_en    (clk_en),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .done      (done),
        .rx_data   (rx_data)
    );

    logic unused_busy;
    assign unused_busy = busy;
endmodule

// File: rtl/mdio_cmd_engine_chk.sv
`timescale 1ns/1ps
module mdio_cmd_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic        req_bit,
    input logic [31:0] reg_rdata,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);
    assert_busy_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_rdata[31]) |-> $past(reg_wr && req_bit));

    assert_mdc_idle_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[31] |-> !mdc);

    assert_mdc_rise_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> reg_rdata[31]);

    assert_mdio_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_oe && $past(mdio_oe) && !$stable(mdio_o)) |-> $fell(mdc));

    assert_fields_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[31] && $past(reg_rdata[31])) |-> $stable(reg_rdata[30:0]));

    assert_idle_undriven_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[31] |-> !mdio_oe);

    assert_spare_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[29:26] == 4'b0000);
endmodule

bind mdio_cmd_engine mdio_cmd_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .req_bit   (reg_wdata[31]),
    .reg_rdata (reg_rdata),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
);

// File: tb/mdio_cmd_engine_tb.sv
`timescale 1ns/1ps
module mdio_cmd_engine_tb;
    localparam int DIV_HALF = 2;
    localparam time HALF_T  = DIV_HALF * 10;

    // {rd, phy[4:0], reg[4:0], wdata[15:0], phy response[15:0]}
    localparam logic [42:0] VECS [4] = '{
        {1'b0, 5'd1,  5'd0,  16'h1234, 16'h0000},
        {1'b1, 5'd31, 5'd31, 16'h0000, 16'hA5C3},
        {1'b0, 5'd0,  5'd31, 16'hFFFF, 16'h0000},
        {1'b1, 5'd16, 5'd2,  16'h0000, 16'h0001}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int n_chk = 0;
    int n_fail = 0;

    logic        cap_v  [64];
    logic        cap_oe [64];
    int          rise_cnt = 0;
    time         t_rise = 0, t_fall = 0;
    int          bad_width = 0;
    int          widths_seen = 0;
    int          bad_edge = 0;
    logic        cur_rd = 1'b0;
    logic [15:0] cur_resp = '0;
    logic        prev_mdc = 1'b0, prev_o = 1'b1, prev_oe = 1'b0;

    mdio_cmd_engine #(.DIV_HALF(DIV_HALF)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_i)
    );

    always #5 clk = ~clk;

    // PHY-side capture at MDC rising edges, width measurement
    always @(posedge mdc) begin
        cap_v[rise_cnt % 64]  = mdio_o;
        cap_oe[rise_cnt % 64] = mdio_oe;
        if ((rise_cnt % 64) != 0) begin
            widths_seen++;
            if ($time - t_fall != HALF_T) bad_width++;
        end
        rise_cnt++;
        t_rise = $time;
    end

    // PHY model: present read data after MDC falls
    always @(negedge mdc) begin
        t_fall = $time;
        widths_seen++;
        if (t_fall - t_rise != HALF_T) bad_width++;
        if (cur_rd && (rise_cnt % 64) >= 48)
            mdio_i = cur_resp[63 - (rise_cnt % 64)];
        else
            mdio_i = 1'b1;
    end

    // Driven MDIO may change only in the cycle MDC falls
    always @(negedge clk) begin
        if (rst_n && mdio_oe && prev_oe && (mdio_o != prev_o) && !(prev_mdc && !mdc))
            bad_edge++;
        prev_mdc = mdc;
        prev_o   = mdio_o;
        prev_oe  = mdio_oe;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_reg(input logic [31:0] d);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic wait_idle(input string tag);
        int n = 0;
        while (reg_rdata[31] && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(!reg_rdata[31], tag, {31'd0, reg_rdata[31]}, 32'd0);
        repeat (3) @(negedge clk);
    endtask

    // Compare captured frame with the expected bit sequence; returns mismatches
    function automatic int frame_errs(input logic rd, input logic [4:0] phy,
                                      input logic [4:0] ra, input logic [15:0] wd);
        logic [63:0] f;
        int errs = 0;
        f = {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, phy, ra, 2'b10, wd};
        for (int i = 0; i < 64; i++) begin
            logic exp_oe;
            exp_oe = !(rd && i >= 46);
            if (cap_oe[i] !== exp_oe) errs++;
            else if (exp_oe && cap_v[i] !== f[63 - i]) errs++;
        end
        return errs;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [42:0] v;
        logic        rd;
        logic [4:0]  phy, ra;
        logic [15:0] wd, rs;
        logic [31:0] exp_rb;
        int          r0;

        // R1: reset state
        repeat (4) @(negedge clk);
        chk(reg_rdata == 32'd0, "R1 readback", reg_rdata, 32'd0);
        chk(mdc == 1'b0, "R1 mdc", {31'd0, mdc}, 32'd0);
        chk(mdio_oe == 1'b0, "R1 oe", {31'd0, mdio_oe}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Vector table: one frame per entry
        for (int k = 0; k < 4; k++) begin
            v   = VECS[k];
            rd  = v[42];
            phy = v[41:37];
            ra  = v[36:32];
            wd  = v[31:16];
            rs  = v[15:0];
            cur_rd   = rd;
            cur_resp = rs;
            write_reg({1'b1, rd, 4'b0000, phy, ra, rd ? 16'h0000 : wd});
            chk(reg_rdata[31] == 1'b1, "R2 busy after request", reg_rdata, {1'b1, 31'd0});
            wait_idle("R2 request clears");
            chk(frame_errs(rd, phy, ra, wd) == 0, "R5 frame bits",
                32'(frame_errs(rd, phy, ra, wd)), 32'd0);
            if (rd)
                chk(cap_oe[46] == 1'b0 && cap_oe[47] == 1'b0, "R7 read turnaround released",
                    {30'd0, cap_oe[46], cap_oe[47]}, 32'd0);
            else
                chk(cap_oe[46] && cap_oe[47] && cap_v[46] == 1'b1 && cap_v[47] == 1'b0,
                    "R7 write turnaround 10", {30'd0, cap_v[46], cap_v[47]}, 32'd2);
            exp_rb = {1'b0, rd, 4'b0000, phy, ra, rd ? rs : wd};
            chk(reg_rdata == exp_rb, "R8 completion readback", reg_rdata, exp_rb);
        end

        // R9: a write during a frame is ignored
        cur_rd = 1'b0;
        write_reg({1'b1, 1'b0, 4'b0000, 5'd3, 5'd7, 16'hBEEF});
        repeat (60) @(negedge clk);
        write_reg(32'hC3FF_0000);
        exp_rb = {1'b1, 1'b0, 4'b0000, 5'd3, 5'd7, 16'hBEEF};
        chk(reg_rdata == exp_rb, "R9 fields held mid-frame", reg_rdata, exp_rb);
        wait_idle("R9 frame ends");
        chk(frame_errs(1'b0, 5'd3, 5'd7, 16'hBEEF) == 0, "R9 frame unaltered",
            32'(frame_errs(1'b0, 5'd3, 5'd7, 16'hBEEF)), 32'd0);
        r0 = rise_cnt;
        repeat (60) @(negedge clk);
        chk(rise_cnt == r0 && !reg_rdata[31], "R9 no follow-on frame", 32'(rise_cnt - r0), 32'd0);
        exp_rb[31] = 1'b0;
        chk(reg_rdata == exp_rb, "R9 readback after frame", reg_rdata, exp_rb);

        // R10 and R3: fields stored without request, spare bits read 0
        write_reg(32'h7D4A_5A5A);
        r0 = rise_cnt;
        repeat (60) @(negedge clk);
        exp_rb = 32'h414A_5A5A;
        chk(reg_rdata == exp_rb, "R10 R3 stored fields", reg_rdata, exp_rb);
        chk(rise_cnt == r0 && !mdc && !mdio_oe, "R10 no frame", 32'(rise_cnt - r0), 32'd0);

        // R4 and R6 summaries from the monitors
        chk(bad_width == 0 && widths_seen > 0, "R4 MDC half period", 32'(bad_width), 32'd0);
        chk(bad_edge == 0, "R6 MDIO change on MDC fall", 32'(bad_edge), 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule